// File: doc/BRIEF.md
# Tournament Hybrid Branch Direction Predictor

This block guesses whether a conditional branch will be taken. It runs two direction predictors side by side and uses a third table to choose between them for each branch. The first predictor is a table of 2-bit saturating counters addressed by the low bits of the branch PC. The second predictor keeps a shift register of recent outcomes from all branches and addresses its own counter table with that history XORed into the PC bits. A chooser table, also addressed by low PC bits, holds 2-bit counters. Each chooser counter leans toward whichever component has been right more often for that slot.

The fetch stage presents a PC on the lookup port. One cycle later the block returns the chosen direction and both component guesses. The pipeline carries the two component guesses alongside the branch. When the branch resolves, it returns the PC, the real outcome and those two guesses on the update port. The update trains both component tables and the chooser, and shifts the outcome into the history.

Top module: `tourney_bp`

## Requirements
- R1: After reset every counter in all three tables is 01 (weakly not taken) and the history is zero, so each lookup returns 0 on pred_taken, pred_bim and pred_gsh.
- R2: pred_bim is bit 1 of the local-table counter at index lk_pc[IDX_W-1:0]. PC bits above IDX_W have no effect on it.
- R3: pred_gsh is bit 1 of the global-table counter at index lk_pc[IDX_W-1:0] XOR history.
- R4: Each update shifts the history left by one and places up_taken in bit 0. Without an update the history holds.
- R5: On each update the local counter at up_pc[IDX_W-1:0] and the global counter at up_pc[IDX_W-1:0] XOR history change as follows. The history used is the value before that update's shift. Each counter steps up by one on a taken outcome, saturating at 11, and down by one on a not-taken outcome, saturating at 00.
- R6: On an update the chooser counter at up_pc[IDX_W-1:0] changes as follows:
  - It steps up, saturating at 11, when up_gsh equals up_taken and up_bim does not.
  - It steps down, saturating at 00, when up_bim equals up_taken and up_gsh does not.
  - In all other cases it holds.
- R7: pred_taken equals pred_gsh when bit 1 of the chooser counter at lk_pc[IDX_W-1:0] is 1, and equals pred_bim otherwise.
- R8: pred_valid is lk_valid delayed by one cycle. The three prediction outputs hold their values in the cycle after a cycle with no lookup.
- R9: When a lookup and an update occur in the same cycle, the lookup returns values computed from the table and history contents before that update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_valid | input | 1 | Lookup request |
| lk_pc | input | PC_W | PC of the branch being looked up |
| pred_valid | output | 1 | Prediction outputs carry a new result |
| pred_taken | output | 1 | Chosen direction, 1 = taken |
| pred_bim | output | 1 | Direction from the PC-indexed table |
| pred_gsh | output | 1 | Direction from the history-indexed table |
| up_valid | input | 1 | Resolved branch update |
| up_pc | input | PC_W | PC of the resolved branch |
| up_taken | input | 1 | Actual outcome, 1 = taken |
| up_bim | input | 1 | PC-indexed guess recorded at lookup |
| up_gsh | input | 1 | History-indexed guess recorded at lookup |

## Verification
The bench builds the block with IDX_W=3 and PC_W=8. With these values each table has eight entries and the history is three bits long, so a few hundred random updates visit every counter at both saturation ends. The same run takes the history through every value and walks every chooser slot through all four states. Each lookup PC is drawn from the full 8-bit range, which checks that the upper bits are ignored. Lookups land on the updated slot in the same cycle as an update, which covers the pre-update read.

// File: rtl/tourney_bp.sv
module tourney_bp #(
  parameter int PC_W  = 32,
  parameter int IDX_W = 10
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            lk_valid,
  input  logic [PC_W-1:0] lk_pc,
  output logic            pred_valid,
  output logic            pred_taken,
  output logic            pred_bim,
  output logic            pred_gsh,
  input  logic            up_valid,
  input  logic [PC_W-1:0] up_pc,
  input  logic            up_taken,
  input  logic            up_bim,
  input  logic            up_gsh
);
  localparam int DEPTH = 1 << IDX_W;

  logic [1:0]       loc_t [DEPTH];
  logic [1:0]       glb_t [DEPTH];
  logic [1:0]       sel_t [DEPTH];
  logic [IDX_W-1:0] hist;

  wire [IDX_W-1:0] lk_li = lk_pc[IDX_W-1:0];
  wire [IDX_W-1:0] lk_gi = lk_li ^ hist;
  wire [IDX_W-1:0] up_li = up_pc[IDX_W-1:0];
  wire [IDX_W-1:0] up_gi = up_li ^ hist;

  wire gsh_only = (up_gsh == up_taken) && (up_bim != up_taken);
  wire bim_only = (up_bim == up_taken) && (up_gsh != up_taken);

  function automatic logic [1:0] step2(input logic [1:0] c, input logic up);
    if (up) return (c == 2'b11) ? c : c + 2'b01;
    else    return (c == 2'b00) ? c : c - 2'b01;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) begin
        loc_t[i] <= 2'b01;
        glb_t[i] <= 2'b01;
        sel_t[i] <= 2'b01;
      end
      hist <= '0;
    end else if (up_valid) begin
      loc_t[up_li] <= step2(loc_t[up_li], up_taken);
      glb_t[up_gi] <= step2(glb_t[up_gi], up_taken);
      if (gsh_only)      sel_t[up_li] <= step2(sel_t[up_li], 1'b1);
      else if (bim_only) sel_t[up_li] <= step2(sel_t[up_li], 1'b0);
      hist <= {hist[IDX_W-2:0], up_taken};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pred_valid <= 1'b0;
      pred_taken <= 1'b0;
      pred_bim   <= 1'b0;
      pred_gsh   <= 1'b0;
    end else begin
      pred_valid <= lk_valid;
      if (lk_valid) begin
        pred_bim   <= loc_t[lk_li][1];
        pred_gsh   <= glb_t[lk_gi][1];
        pred_taken <= sel_t[lk_li][1] ? glb_t[lk_gi][1] : loc_t[lk_li][1];
      end
    end
  end
endmodule

// File: rtl/tourney_bp_chk.sv
module tourney_bp_chk #(
  parameter int IDX_W = 10
) (
  input logic             clk,
  input logic             rst_n,
  input logic             lk_valid,
  input logic             pred_valid,
  input logic             pred_taken,
  input logic             pred_bim,
  input logic             pred_gsh,
  input logic             up_valid,
  input logic             up_taken,
  input logic [IDX_W-1:0] hist
);
  // R8
  valid_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pred_valid == $past(lk_valid));

  // R8
  hold_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(lk_valid) |-> $stable({pred_taken, pred_bim, pred_gsh}));

  // R7
  pick_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pred_taken == pred_bim) || (pred_taken == pred_gsh));

  // R4
  hist_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(up_valid) |-> hist == {$past(hist[IDX_W-2:0]), $past(up_taken)});

  // R4
  hist_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(up_valid) |-> $stable(hist));
endmodule

bind tourney_bp tourney_bp_chk #(.IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .pred_valid(pred_valid),
  .pred_taken(pred_taken), .pred_bim(pred_bim), .pred_gsh(pred_gsh),
  .up_valid(up_valid), .up_taken(up_taken), .hist(hist)
);

// File: tb/tourney_bp_tb.sv
`timescale 1ns/1ps
module tourney_bp_tb;
  localparam int PC_W = 8;
  localparam int IW   = 3;
  localparam int D    = 1 << IW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic lk_valid = 1'b0, up_valid = 1'b0;
  logic [PC_W-1:0] lk_pc = '0, up_pc = '0;
  logic up_taken = 1'b0, up_bim = 1'b0, up_gsh = 1'b0;
  logic pred_valid, pred_taken, pred_bim, pred_gsh;

  always #4 clk = ~clk;

  tourney_bp #(.PC_W(PC_W), .IDX_W(IW)) u_dut (
    .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_pc(lk_pc),
    .pred_valid(pred_valid), .pred_taken(pred_taken), .pred_bim(pred_bim),
    .pred_gsh(pred_gsh), .up_valid(up_valid), .up_pc(up_pc),
    .up_taken(up_taken), .up_bim(up_bim), .up_gsh(up_gsh)
  );

  int nvec = 0, nbad = 0;
  logic [1:0]    m_loc [D];
  logic [1:0]    m_glb [D];
  logic [1:0]    m_sel [D];
  logic [IW-1:0] m_hist = '0;
  logic e_t = 1'b0, e_b = 1'b0, e_g = 1'b0;
  logic [15:0] lfsr = 16'hACE1;

  function automatic logic [1:0] sat(input logic [1:0] c, input logic up);
    if (up) return (c == 3) ? c : c + 1;
    return (c == 0) ? c : c - 1;
  endfunction

  function automatic logic [15:0] rnd(input logic [15:0] s);
    return {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
  endfunction

  task automatic chk(input logic act, input logic exp, input string tag);
    nvec++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s: actual %0b expected %0b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step(input logic lk, input logic [PC_W-1:0] lpc,
                      input logic up, input logic [PC_W-1:0] upc,
                      input logic ut, input logic ub, input logic ug);
    logic [IW-1:0] li, gi, ul, ugi;
    @(negedge clk);
    lk_valid = lk; lk_pc = lpc;
    up_valid = up; up_pc = upc; up_taken = ut; up_bim = ub; up_gsh = ug;
    if (lk) begin
      li  = lpc[IW-1:0];
      gi  = li ^ m_hist;
      e_b = m_loc[li][1];
      e_g = m_glb[gi][1];
      e_t = m_sel[li][1] ? e_g : e_b;
    end
    if (up) begin
      ul  = upc[IW-1:0];
      ugi = ul ^ m_hist;
      m_loc[ul]  = sat(m_loc[ul], ut);
      m_glb[ugi] = sat(m_glb[ugi], ut);
      if (ug == ut && ub != ut)      m_sel[ul] = sat(m_sel[ul], 1'b1);
      else if (ub == ut && ug != ut) m_sel[ul] = sat(m_sel[ul], 1'b0);
      m_hist = {m_hist[IW-2:0], ut};
    end
    @(posedge clk); #1;
    chk(pred_valid, lk, "R8 valid");
    chk(pred_bim, e_b, (lk && up) ? "R2 R5 R9 bim" : "R2 R5 R8 bim");
    chk(pred_gsh, e_g, (lk && up) ? "R3 R4 R5 R9 gsh" : "R3 R4 R5 R8 gsh");
    chk(pred_taken, e_t, "R6 R7 taken");
  endtask

  task automatic summary;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  endtask

  initial begin
    #2_000_000;
    nbad++;
    $display("FAIL watchdog: actual hung expected done");
    summary();
  end

  initial begin
    for (int i = 0; i < D; i++) begin
      m_loc[i] = 2'b01; m_glb[i] = 2'b01; m_sel[i] = 2'b01;
    end
    repeat (3) @(posedge clk);
    #1;
    chk(pred_valid, 1'b0, "R1 reset valid");
    chk(pred_taken, 1'b0, "R1 reset taken");
    @(negedge clk) rst_n = 1'b1;
    // R1: every slot weakly not taken after reset
    for (int p = 0; p < D; p++) step(1'b1, 8'(p * 37 + 8), 1'b0, 8'h0, 1'b0, 1'b0, 1'b0);
    // R6: chooser climbs and saturates; R9 same-slot reads
    for (int k = 0; k < 5; k++) step(1'b1, 8'h12, 1'b1, 8'h02, 1'b1, 1'b0, 1'b1);
    // R6: chooser falls and saturates
    for (int k = 0; k < 5; k++) step(1'b1, 8'hF2, 1'b1, 8'h42, 1'b0, 1'b0, 1'b1);
    // R5: not-taken floor
    for (int k = 0; k < 5; k++) step(1'b1, 8'h05, 1'b1, 8'h05, 1'b0, 1'b1, 1'b1);
    // R8: idle cycles hold outputs
    for (int k = 0; k < 3; k++) step(1'b0, 8'h00, 1'b0, 8'h0, 1'b0, 1'b0, 1'b0);
    for (int k = 0; k < 800; k++) begin
      logic [15:0] a, b;
      lfsr = rnd(lfsr); a = lfsr;
      lfsr = rnd(lfsr); b = lfsr;
      if (a[15:13] == 0) b[2:0] = a[2:0];
      step(a[12] | a[11], a[7:0], b[15] | b[14], {b[13:9], b[2:0]}, b[8], b[4], a[9]);
    end
    // R2 R3: closing sweep of every slot
    for (int p = 0; p < D; p++) step(1'b1, 8'(p + 8'hC0), 1'b0, 8'h0, 1'b0, 1'b0, 1'b0);
    summary();
  end
endmodule